// File: doc/BRIEF.md
# Vectored Critical Interrupt Controller

This block gathers 32 interrupt request lines and folds them into two processor-facing request lines. One is a normal request and one is a critical request. Every input can be set to capture either edges or levels. Each input passes a synchronizer before capture. A per-bit class register sends each enabled pending request either to the normal line or to the critical line.

For critical requests the block also builds a jump vector in hardware. The vector is a programmable base address plus 512 times the position of the first pending critical bit. Software picks the scan direction with bit 0 of the vector configuration register.

Software reaches the block through a simple register port with address, read strobe, write strobe and data lines. The window is nine words long and starts at a configurable base (0xC0 by default). Reads return data combinationally in the same cycle as the read strobe. Every register clears on reset.

Top module: `crit_vic`

## Requirements
- R1: After reset every register reads zero and both request outputs are low.
- R2: Input line n sets bit (31 − n) of the status register; for example, input 3 sets bit 28.
- R3: When the trigger-type bit (offset 5) of an input is 1, a rising input sets its status bit and the later fall leaves the bit set.
- R4: When the trigger-type bit is 0, the status bit follows the input: it rises when the input rises and clears when the input falls.
- R5: A write to offset 0 clears each status bit written as 1. Afterwards, bits of level-mode inputs that are still high stay set.
- R6: A write to offset 1 ORs the written value into status. Reads of offsets 0 and 1 both return status.
- R7: The normal output is high when any bit of status & enable (offset 2) & ~class (offset 3) is set. The critical output is high when any bit of status & enable & class is set.
- R8: When bit 0 of the vector configuration (offset 8) is 0, the lowest pending critical bit i is chosen. The vector (offset 7) is then (config & ~3) + i·512.
- R9: When configuration bit 0 is 1, the highest pending critical bit i is chosen. The vector is then (config & ~3) + (31 − i)·512.
- R10: With no critical request pending, the vector reads 0 and the critical output is low.
- R11: Writes to offset 8 store bit 1 as 0. Writes to offsets 6 and 7 change nothing. Offset 6 reads status & enable.
- R12: The polarity register (offset 4) reads back what was written and does not change capture. Reads outside the nine-word window return 0.
- R13: The status bit changes on the third rising clock edge after an input changes. The outputs and the vector change on the first rising edge after a status or register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Asynchronous interrupt request lines, line n maps to status bit 31−n |
| bus_addr | input | 10 | Register address, compared against the window base |
| bus_wr | input | 1 | Write strobe, acted on at the rising edge |
| bus_rd | input | 1 | Read strobe, qualifies read data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and strobe |
| irq_normal | output | 1 | Normal-class interrupt request |
| irq_crit | output | 1 | Critical-class interrupt request |

## Verification
An input change first appears in status after three rising edges: two synchronizer stages and the capture register. The request lines and the vector follow one edge later. A register write takes effect at the edge that captures it, and its effect on the outputs shows one edge after that. The bench drives inputs and strobes just after a falling edge and samples at later falling edges. It counts whole cycles to each of these points. The latency scenario checks both sides of each boundary: the cycle before the change and the cycle of the change.

// File: rtl/crit_vic_pkg.sv
package crit_vic_pkg;

   typedef enum logic [3:0] {
      OFF_STAT  = 4'd0,
      OFF_SSET  = 4'd1,
      OFF_EN    = 4'd2,
      OFF_CLASS = 4'd3,
      OFF_POL   = 4'd4,
      OFF_TRIG  = 4'd5,
      OFF_MSTAT = 4'd6,
      OFF_VEC   = 4'd7,
      OFF_VCFG  = 4'd8
   } reg_off_e;

   localparam int unsigned NUM_OFFS = 9;

endpackage

// File: rtl/crit_vic_capture.sv
module crit_vic_capture #(
   parameter int unsigned W           = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("crit_vic_capture: SYNC_STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [SYNC_STAGES];
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(SYNC_STAGES); s++) chain_q[s] <= '0;
         prev_q <= '0;
      end else begin
         chain_q[0] <= raw;
         for (int s = 1; s < int'(SYNC_STAGES); s++) chain_q[s] <= chain_q[s-1];
         prev_q <= chain_q[SYNC_STAGES-1];
      end
   end

   assign rise = chain_q[SYNC_STAGES-1] & ~prev_q;
   assign fall = ~chain_q[SYNC_STAGES-1] & prev_q;

endmodule

// File: rtl/crit_vic_vector.sv
module crit_vic_vector #(
   parameter int unsigned W           = 32,
   parameter int unsigned STRIDE_LOG2 = 9
) (
   input  logic [W-1:0] pend,
   input  logic [W-3:0] base_hi,
   input  logic         scan_down,
   output logic         any,
   output logic [W-1:0] vec
);

   localparam int unsigned POS_W = $clog2(W);

   if (STRIDE_LOG2 + POS_W > W) begin : g_bad_stride
      $error("crit_vic_vector: stride times positions exceeds vector width");
   end

   logic [W-1:0]     scanv;
   logic [POS_W-1:0] pos;
   logic             found;

   always_comb begin
      for (int i = 0; i < int'(W); i++) begin
         scanv[i] = scan_down ? pend[W-1-i] : pend[i];
      end
      pos   = '0;
      found = 1'b0;
      for (int i = 0; i < int'(W); i++) begin
         if (!found && scanv[i]) begin
            pos   = POS_W'(i);
            found = 1'b1;
         end
      end
   end

   assign any = found;
   assign vec = found ? ({base_hi, 2'b00} + (W'(pos) << STRIDE_LOG2)) : '0;

endmodule

// File: rtl/crit_vic.sv
module crit_vic
   import crit_vic_pkg::*;
#(
   parameter int unsigned      DATA_W      = 32,
   parameter int unsigned      ADDR_W      = 10,
   parameter logic [ADDR_W-1:0] BASE       = 10'h0C0,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter int unsigned      STRIDE_LOG2 = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] irq_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_normal,
   output logic              irq_crit
);

   localparam int unsigned NIRQ = DATA_W;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("crit_vic: ADDR_W must hold the nine-word window");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("crit_vic: DATA_W too small");
   end

   // input line n lands on register bit NIRQ-1-n
   logic [NIRQ-1:0] irq_bits;
   for (genvar n = 0; n < int'(NIRQ); n++) begin : g_map
      assign irq_bits[NIRQ-1-n] = irq_in[n];
   end

   logic [NIRQ-1:0] rise, fall;

   crit_vic_capture #(.W(NIRQ), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (irq_bits),
      .rise (rise),
      .fall (fall)
   );

   // register window decode
   logic [ADDR_W-1:0] rel;
   logic              hit;
   logic [3:0]        off;
   assign rel = bus_addr - BASE;
   assign hit = (bus_addr >= BASE) && (rel < ADDR_W'(NUM_OFFS));
   assign off = rel[3:0];

   logic wr_stat, wr_sset, wr_en, wr_class, wr_pol, wr_trig, wr_vcfg;
   assign wr_stat  = bus_wr && hit && (off == OFF_STAT);
   assign wr_sset  = bus_wr && hit && (off == OFF_SSET);
   assign wr_en    = bus_wr && hit && (off == OFF_EN);
   assign wr_class = bus_wr && hit && (off == OFF_CLASS);
   assign wr_pol   = bus_wr && hit && (off == OFF_POL);
   assign wr_trig  = bus_wr && hit && (off == OFF_TRIG);
   assign wr_vcfg  = bus_wr && hit && (off == OFF_VCFG);

   logic [DATA_W-1:0] stat_q, lvl_q, en_q, class_q, pol_q, trig_q, vcfg_q, vec_q;
   logic [DATA_W-1:0] stat_d, lvl_d;

   // capture events first, then software clear or set in the same cycle
   always_comb begin
      lvl_d  = (lvl_q | (rise & ~trig_q)) & ~(fall & ~trig_q);
      stat_d = (stat_q | rise) & ~(fall & ~trig_q);
      if (wr_stat)      stat_d = (stat_d & ~bus_wdata) | lvl_d;
      else if (wr_sset) stat_d = stat_d | bus_wdata;
   end

   logic [DATA_W-1:0] pend_n, pend_c, vec_d;
   logic              crit_any;
   assign pend_n = stat_q & en_q & ~class_q;
   assign pend_c = stat_q & en_q & class_q;

   crit_vic_vector #(.W(DATA_W), .STRIDE_LOG2(STRIDE_LOG2)) u_vec (
      .pend     (pend_c),
      .base_hi  (vcfg_q[DATA_W-1:2]),
      .scan_down(vcfg_q[0]),
      .any      (crit_any),
      .vec      (vec_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q     <= '0;
         lvl_q      <= '0;
         en_q       <= '0;
         class_q    <= '0;
         pol_q      <= '0;
         trig_q     <= '0;
         vcfg_q     <= '0;
         vec_q      <= '0;
         irq_normal <= 1'b0;
         irq_crit   <= 1'b0;
      end else begin
         stat_q     <= stat_d;
         lvl_q      <= lvl_d;
         if (wr_en)    en_q    <= bus_wdata;
         if (wr_class) class_q <= bus_wdata;
         if (wr_pol)   pol_q   <= bus_wdata;
         if (wr_trig)  trig_q  <= bus_wdata;
         if (wr_vcfg)  vcfg_q  <= bus_wdata & ~DATA_W'(2);
         vec_q      <= vec_d;
         irq_normal <= |pend_n;
         irq_crit   <= crit_any;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && hit) begin
         case (off)
            OFF_STAT, OFF_SSET: bus_rdata = stat_q;
            OFF_EN:             bus_rdata = en_q;
            OFF_CLASS:          bus_rdata = class_q;
            OFF_POL:            bus_rdata = pol_q;
            OFF_TRIG:           bus_rdata = trig_q;
            OFF_MSTAT:          bus_rdata = stat_q & en_q;
            OFF_VEC:            bus_rdata = vec_q;
            OFF_VCFG:           bus_rdata = vcfg_q;
            default:            bus_rdata = '0;
         endcase
      end
   end

   // R3: an edge-mode status bit stays set until software clears it
   a_r3_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_stat) |-> (($past(stat_q) & $past(trig_q) & ~stat_q) == '0));

   // R5: a tracked active level is always reflected in status
   a_r5_level_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q & ~stat_q) == '0);

   // R10: vector is zero whenever the critical line is low
   a_r10_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_crit |-> (vec_q == '0));

   // R11: configuration bit 1 never holds a one
   a_r11_cfg_bit1: assert property (@(posedge clk) disable iff (!rst_n)
      vcfg_q[1] == 1'b0);

endmodule

// File: tb/crit_vic_bench.sv
`timescale 1ns/1ps
module crit_vic_bench;

   localparam logic [9:0] BASE = 10'h0C0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic [9:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_normal, irq_crit;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   crit_vic u_crit_vic (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_normal(irq_normal), .irq_crit(irq_crit)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int o, input logic [31:0] d);
      @(negedge clk);
      bus_addr = BASE + 10'(o); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_abs(input logic [9:0] a, output logic [31:0] v);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic rd(input int o, output logic [31:0] v);
      rd_abs(BASE + 10'(o), v);
   endtask

   task automatic set_in(input logic [31:0] v);
      @(negedge clk);
      irq_in = v;
   endtask

   task automatic cleanup();
      set_in('0);
      wr(5, 0); wr(2, 0); wr(3, 0); wr(8, 0);
      settle(4);
      wr(0, 32'hFFFF_FFFF);
      settle(2);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int o = 0; o < 9; o++) begin
         rd(o, v);
         chk("R1 reset register", v, 0);
      end
      chk("R1 normal low", 32'(irq_normal), 0);
      chk("R1 crit low", 32'(irq_crit), 0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      set_in(32'h0000_0008);
      settle(4);
      rd(0, v); chk("R2 R4 level input 3 on bit 28", v, 32'h1000_0000);
      wr(2, 32'h1000_0000);
      settle(1);
      chk("R7 normal raised", 32'(irq_normal), 1);
      chk("R7 crit stays low", 32'(irq_crit), 0);
      wr(0, 32'hFFFF_FFFF);
      settle(1);
      rd(0, v); chk("R5 active level survives clear", v, 32'h1000_0000);
      set_in('0);
      settle(4);
      rd(0, v); chk("R4 level fall clears", v, 0);
      chk("R7 normal dropped", 32'(irq_normal), 0);
      cleanup();
   endtask

   task automatic t_edge();
      logic [31:0] v;
      wr(5, 32'h0400_0000);
      set_in(32'h0000_0020);
      settle(4);
      set_in('0);
      settle(4);
      rd(0, v); chk("R3 edge bit held after fall", v, 32'h0400_0000);
      wr(0, 32'h0400_0000);
      settle(1);
      rd(0, v); chk("R5 edge bit cleared by write", v, 0);
      cleanup();
   endtask

   task automatic t_set_mask();
      logic [31:0] v;
      wr(1, 32'h00F0_0001);
      rd(0, v); chk("R6 status after set", v, 32'h00F0_0001);
      rd(1, v); chk("R6 offset 1 reads status", v, 32'h00F0_0001);
      wr(2, 32'h0030_0001);
      rd(6, v); chk("R11 masked status", v, 32'h0030_0001);
      wr(6, 32'hFFFF_FFFF);
      wr(7, 32'hFFFF_FFFF);
      settle(1);
      rd(0, v); chk("R11 status untouched by offset 6/7 writes", v, 32'h00F0_0001);
      rd(6, v); chk("R11 masked status untouched", v, 32'h0030_0001);
      rd(7, v); chk("R11 vector untouched", v, 0);
      cleanup();
   endtask

   task automatic t_crit();
      logic [31:0] v;
      wr(2, 32'hFFFF_FFFF);
      wr(3, 32'h0000_0110);
      wr(8, 32'h1000_0003);
      rd(8, v); chk("R11 config bit 1 dropped", v, 32'h1000_0001);
      wr(1, 32'h0000_0110);
      settle(1);
      chk("R7 crit raised", 32'(irq_crit), 1);
      chk("R7 normal low for critical bits", 32'(irq_normal), 0);
      rd(7, v); chk("R9 downward scan bit 8", v, 32'h1000_2E00);
      wr(8, 32'h1000_0000);
      settle(1);
      rd(7, v); chk("R8 upward scan bit 4", v, 32'h1000_0800);
      wr(1, 32'h8000_0000);
      settle(1);
      chk("R7 normal raised beside critical", 32'(irq_normal), 1);
      wr(0, 32'h0000_0110);
      settle(1);
      chk("R10 crit dropped", 32'(irq_crit), 0);
      rd(7, v); chk("R10 vector zero", v, 0);
      wr(3, 32'h0000_0001);
      wr(1, 32'h0000_0001);
      settle(1);
      rd(7, v); chk("R8 upward scan bit 0", v, 32'h1000_0000);
      wr(8, 32'h1000_0001);
      settle(1);
      rd(7, v); chk("R9 downward scan bit 0", v, 32'h1000_3E00);
      cleanup();
   endtask

   task automatic t_pol();
      logic [31:0] v;
      wr(4, 32'hA5A5_0000);
      rd(4, v); chk("R12 polarity readback", v, 32'hA5A5_0000);
      set_in(32'h0000_0001);
      settle(4);
      rd(0, v); chk("R12 R2 capture unaffected by polarity", v, 32'h8000_0000);
      rd_abs(BASE + 10'd9, v); chk("R12 read above window", v, 0);
      rd_abs(BASE - 10'd1, v); chk("R12 read below window", v, 0);
      cleanup();
   endtask

   task automatic t_latency();
      logic [31:0] v;
      wr(2, 32'h4000_0000);
      set_in(32'h0000_0002);
      settle(2);
      rd(0, v); chk("R13 status not yet after two edges", v, 0);
      settle(1);
      rd(0, v); chk("R13 status on third edge", v, 32'h4000_0000);
      chk("R13 normal not yet", 32'(irq_normal), 0);
      settle(1);
      chk("R13 normal one edge after status", 32'(irq_normal), 1);
      wr(2, 0);
      chk("R13 normal holds at enable capture edge", 32'(irq_normal), 1);
      settle(1);
      chk("R13 normal drops one edge later", 32'(irq_normal), 0);
      cleanup();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle(2);
      t_reset();
      t_level();
      t_edge();
      t_set_mask();
      t_crit();
      t_pol();
      t_latency();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule